// File: doc/BRIEF.md
# Core Run/Stop Controller

This block starts and stops a set of processor cores within a cluster. It keeps a running bitmap with one bit for each core. Software writes a bitmask to a run register to bring cores up. Each named core that is idle gets a one-cycle reset pulse and is marked running. Software writes a bitmask to a stop register to bring cores down. Each named core that is running gets a one-cycle halt pulse and is marked idle. Cores whose state would not change are left alone.

The registers sit on a plain register bus: address, write strobe, write data, read strobe and read data. They appear twice, once in a local window and once in an other-core window, and both copies behave the same. After power-on reset the bitmap is empty. In the first clock after reset is released, a boot mask parameter is applied as a run operation, so the chosen cores come up with no software action. The bus carries control writes and status reads only, with no streaming data, so it has no valid/ready handshake. A write is taken in the cycle its strobe is high. Read data is combinational from the address while the read strobe is high.

Top module: `core_runctl`

## Requirements
- R1: Only write-data bits 0 to NUM_CORES-1 take part in a run or stop operation. Higher bits are ignored, and read data bits at NUM_CORES and above are always zero.
- R2: A run write (byte address 0x2028 or 0x4028) raises core_rst[i] for each core i that is named in the data and is idle. The running bit of that core is set at the same clock edge. Named cores that are already running get no pulse.
- R3: A stop write (byte address 0x2020 or 0x4020) raises core_halt[i] for each core i that is named in the data and is running. Its running bit is cleared at the same edge. Named cores that are already idle get no pulse.
- R4: Each core_rst and core_halt pulse is high for exactly one clock cycle.
- R5: While bus_rd is high at byte address 0x2030 or 0x4030, bus_rdata returns the running bitmap, with core i at bit i. At any other address, or while bus_rd is low, bus_rdata is zero.
- R6: The local window (0x2000 base) and the other-core window (0x4000 base) give the same result for run, stop and status.
- R7: A write to any address other than the four run and stop addresses changes neither the running bitmap nor the pulse outputs.
- R8: While rst_n is low, the bitmap is clear and no pulses are driven. In the first clock edge after release, BOOT_MASK is applied as a run operation.
- R9: A BOOT_MASK with a bit set at or above NUM_CORES is a configuration error and is flagged at start of simulation.
- R10: When a core is named by a stop and a run in the same cycle (a bus stop during the boot cycle), the stop wins and the run is suppressed for that core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_addr | input | 16 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 64 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 64 | Read data, combinational |
| core_rst | output | NUM_CORES | One-cycle reset pulse per core |
| core_halt | output | NUM_CORES | One-cycle halt pulse per core |

## Verification
The run and stop operations are driven with masks that overlap the running set partly, fully and not at all. This separates "act on the state change only" from "act on every named bit". Each operation is applied through both windows, and the result is read back through both status aliases, to show that the aliases are equal. Data with only high bits set and writes to the status and unmapped offsets show that masking and address decode leave the state untouched. A stop written during the boot cycle shows which side wins a same-cycle conflict.

// File: rtl/runctl_pkg.sv
package runctl_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 64;

  localparam logic [ADDR_W-1:0] WIN_LOCAL = 16'h2000;
  localparam logic [ADDR_W-1:0] WIN_OTHER = 16'h4000;
  localparam logic [ADDR_W-1:0] OFS_STOP  = 16'h0020;
  localparam logic [ADDR_W-1:0] OFS_RUN   = 16'h0028;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 16'h0030;

  localparam int NUM_WIN = 2;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_RUN  = 2'd1,
    SEL_STOP = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/runctl_decode.sv
module runctl_decode
  import runctl_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  logic [ADDR_W-1:0] bases [NUM_WIN];
  assign bases[0] = WIN_LOCAL;
  assign bases[1] = WIN_OTHER;

  logic [NUM_WIN-1:0] hit_run, hit_stop, hit_stat;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign hit_run[w]  = (addr_i == bases[w] + OFS_RUN);
    assign hit_stop[w] = (addr_i == bases[w] + OFS_STOP);
    assign hit_stat[w] = (addr_i == bases[w] + OFS_STAT);
  end

  always_comb begin
    if (|hit_run)       sel_o = SEL_RUN;
    else if (|hit_stop) sel_o = SEL_STOP;
    else if (|hit_stat) sel_o = SEL_STAT;
    else                sel_o = SEL_NONE;
  end
endmodule

// File: rtl/runctl_slice.sv
module runctl_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic stop_i,
  output logic running_o,
  output logic rst_pulse_o,
  output logic halt_pulse_o
);
  logic do_start, do_halt;

  // Stop is checked first; a core named by both never starts.
  assign do_halt  = stop_i && running_o;
  assign do_start = run_i && !stop_i && !running_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_o    <= 1'b0;
      rst_pulse_o  <= 1'b0;
      halt_pulse_o <= 1'b0;
    end else begin
      rst_pulse_o  <= do_start;
      halt_pulse_o <= do_halt;
      if (do_halt)       running_o <= 1'b0;
      else if (do_start) running_o <= 1'b1;
    end
  end
endmodule

// File: rtl/core_runctl.sv
module core_runctl
  import runctl_pkg::*;
#(
  parameter int              NUM_CORES = 1,
  parameter logic [63:0]     BOOT_MASK = 64'h1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [15:0]          bus_addr,
  input  logic                 bus_wr,
  input  logic [63:0]          bus_wdata,
  input  logic                 bus_rd,
  output logic [63:0]          bus_rdata,
  output logic [NUM_CORES-1:0] core_rst,
  output logic [NUM_CORES-1:0] core_halt
);
  localparam logic [NUM_CORES-1:0] BOOT_BITS = BOOT_MASK[NUM_CORES-1:0];

  reg_sel_e               sel;
  logic                   boot_q;
  logic [NUM_CORES-1:0]   run_vec, stop_vec, running_q;

  runctl_decode u_dec (.addr_i(bus_addr), .sel_o(sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_q <= 1'b1;
    else        boot_q <= 1'b0;
  end

  always_comb begin
    run_vec  = boot_q ? BOOT_BITS : '0;
    stop_vec = '0;
    if (bus_wr && sel == SEL_RUN)  run_vec  = run_vec | bus_wdata[NUM_CORES-1:0];
    if (bus_wr && sel == SEL_STOP) stop_vec = bus_wdata[NUM_CORES-1:0];
  end

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    runctl_slice u_slice (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_i       (run_vec[i]),
      .stop_i      (stop_vec[i]),
      .running_o   (running_q[i]),
      .rst_pulse_o (core_rst[i]),
      .halt_pulse_o(core_halt[i])
    );
  end

  if (NUM_CORES < 64) begin : g_hi
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^bus_wdata[63:NUM_CORES];
  end

  assign bus_rdata = (bus_rd && sel == SEL_STAT) ? 64'(running_q) : 64'h0;
endmodule

// File: rtl/runctl_checker.sv
module runctl_checker #(
  parameter int          NUM_CORES = 1,
  parameter logic [63:0] BOOT_MASK = 64'h1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CORES-1:0] core_rst,
  input logic [NUM_CORES-1:0] core_halt,
  input logic [NUM_CORES-1:0] running,
  input logic [63:0]          bus_rdata
);
  // R9: boot mask must fit the core count
  initial begin
    a_r9_boot_cfg: assert (NUM_CORES >= 64 || (BOOT_MASK >> NUM_CORES) == 64'h0)
      else $error("boot mask exceeds core count");
  end

  a_r2_rst_sets_running: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst & ~running) == '0);

  a_r3_halt_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (core_halt & running) == '0);

  a_r3_halt_was_running: assert property (@(posedge clk) disable iff (!rst_n)
    (core_halt != '0) |-> (($past(running) & core_halt) == core_halt));

  a_r4_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst != '0) |=> ((core_rst & $past(core_rst)) == '0));

  a_r4_halt_single: assert property (@(posedge clk) disable iff (!rst_n)
    (core_halt != '0) |=> ((core_halt & $past(core_halt)) == '0));

  a_r10_no_both: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst & core_halt) == '0);

  if (NUM_CORES < 64) begin : g_hi
    a_r1_rdata_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[63:NUM_CORES] == '0);
  end
endmodule

bind core_runctl runctl_checker #(.NUM_CORES(NUM_CORES), .BOOT_MASK(BOOT_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .core_halt(core_halt),
  .running(running_q), .bus_rdata(bus_rdata)
);

// File: tb/tb_core_runctl.sv
module tb_core_runctl;
  localparam int N = 4;
  localparam logic [63:0] BOOT = 64'h5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [N-1:0] core_rst, core_halt;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  core_runctl #(.NUM_CORES(N), .BOOT_MASK(BOOT)) dut (.*);

  typedef struct packed {
    logic [15:0] a;
    logic [63:0] d;
    logic [3:0]  er;
    logic [3:0]  eh;
    logic [3:0]  erun;
  } vec_t;

  // Starting from running = 0101 after boot
  localparam vec_t VEC [10] = '{
    '{16'h2028, 64'h3,                 4'b0010, 4'b0000, 4'b0111}, // R2 partial overlap
    '{16'h2020, 64'h6,                 4'b0000, 4'b0110, 4'b0001}, // R3
    '{16'h4028, 64'hFFFF_FFFF_FFFF_FFF0, 4'b0000, 4'b0000, 4'b0001}, // R1 high bits only
    '{16'h4028, 64'hF,                 4'b1110, 4'b0000, 4'b1111}, // R6 other window run
    '{16'h4020, 64'h9,                 4'b0000, 4'b1001, 4'b0110}, // R6 other window stop
    '{16'h2020, 64'h9,                 4'b0000, 4'b0000, 4'b0110}, // R3 already idle
    '{16'h2030, 64'hF,                 4'b0000, 4'b0000, 4'b0110}, // R7 status write
    '{16'h2000, 64'hF,                 4'b0000, 4'b0000, 4'b0110}, // R7 unmapped
    '{16'h2028, 64'h0,                 4'b0000, 4'b0000, 4'b0110}, // R2 empty mask
    '{16'h2028, 64'h6,                 4'b0000, 4'b0000, 4'b0110}  // R2 already running
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [63:0] v);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    bus_rd = 1'b0;
  endtask

  logic [63:0] v;
  bit done = 0;

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 quiet during reset
    check("R8 rst in reset", 64'(core_rst), 64'h0);
    rd(16'h2030, v);
    check("R8 running in reset", v, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 boot rst pulse", 64'(core_rst), BOOT);
    rd(16'h4030, v);
    check("R8 boot running", v, BOOT);
    @(negedge clk);
    check("R4 boot pulse ends", 64'(core_rst), 64'h0);

    for (int k = 0; k < 10; k++) begin
      bus_addr = VEC[k].a; bus_wdata = VEC[k].d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      check($sformatf("R2 rst vec %0d", k), 64'(core_rst), 64'(VEC[k].er));
      check($sformatf("R3 halt vec %0d", k), 64'(core_halt), 64'(VEC[k].eh));
      rd(16'h2030, v);
      check($sformatf("R5 local running vec %0d", k), v, 64'(VEC[k].erun));
      rd(16'h4030, v);
      check($sformatf("R6 other running vec %0d", k), v, 64'(VEC[k].erun));
      @(negedge clk);
      check($sformatf("R4 pulses end vec %0d", k), 64'({core_rst, core_halt}), 64'h0);
    end

    // R5 other offsets and idle strobe read zero
    rd(16'h2028, v);
    check("R5 read run offset", v, 64'h0);
    rd(16'h4034, v);
    check("R5 read unmapped", v, 64'h0);
    bus_addr = 16'h2030; #1;
    check("R5 rd low", bus_rdata, 64'h0);

    // R10: stop written during the boot cycle wins for core 0
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    bus_addr = 16'h2020; bus_wdata = 64'h1; bus_wr = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R10 boot rst with stop", 64'(core_rst), 64'h4);
    check("R10 no halt", 64'(core_halt), 64'h0);
    rd(16'h2030, v);
    check("R10 running", v, 64'h4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule